// File: doc/BRIEF.md
# Three-Phase Six-Step Commutator with Low-Side Chopping

This block turns the three digitized rotor-position sensor bits of a brushless motor into six gate enables for a three-phase bipolar bridge. Each phase has one high-side enable and one low-side enable. In each of the six valid sensor states exactly one phase drives its high-side switch and a different phase drives its low-side switch. A switch that is on is fully on. Drive strength comes only from chopping: the low-side switch of the conducting pair follows a PWM-on signal from an external duty comparator. The high-side switch stays on for the whole commutation step.

Other inputs override the commutation. A start input (low means start) stops the bridge completely when high. A deceleration command either lets the motor coast with all switches off, or applies reverse torque by driving the opposite pair; a mode select picks which. A current-limit trip ends the present PWM on-time, but only after it has held for a blanking window, so that short recovery spikes are ignored. A protection input, latched upstream, holds every low-side switch off. Any change of the conducting pair passes through a fixed dead interval with all six switches off.

Top module: `bldc_commutator`

## Requirements
- R1: With start low, no deceleration, pwm_on_i high and no trip or protection, the sensor code {hall_i[2],hall_i[1],hall_i[0]} selects (high phase, low phase) as follows, phase A being bit 0, B bit 1 and C bit 2 of each enable bus: 001→(A,B), 011→(A,C), 010→(B,C), 110→(B,A), 100→(C,A), 101→(C,B).
- R2: Sensor codes 000 and 111 are invalid. From the next clock edge on, all six enables are off.
- R3: While start_n_i is high, all six enables are off from the next edge on. This holds whatever the deceleration and mode inputs are.
- R4: The low-side enable of the conducting pair follows pwm_on_i with one edge of latency. The high-side enable does not change with pwm_on_i.
- R5: With decel_i high and coast_sel_i high, all six enables are off from the next edge on (coast).
- R6: With decel_i high and coast_sel_i low, each valid code drives the R1 pair with the high and low phases exchanged, which is the table advanced by three steps.
- R7: When the target pair differs from a pair that is on, all six enables go off at the next edge. They stay off for exactly DEAD_CYC edges, and the new pair appears at the following edge.
- R8: At no time is more than one high-side or more than one low-side enable on. The high-side and low-side enables of one phase are never on together.
- R9: A current-limit trip held high for BLANK_CYC consecutive edges clears the low-side enable at the BLANK_CYC-th edge. It stays cleared until pwm_on_i has been sampled low. A trip that drops before BLANK_CYC edges has no effect, and the count restarts.
- R10: While prot_off_i is high, all low-side enables are off from the next edge on. High-side enables are unaffected.
- R11: During reset all six enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Rotor sensor bits, bit n for phase n (A, B, C) |
| pwm_on_i | input | 1 | Duty comparator on-phase |
| ilim_trip_i | input | 1 | Current-limit comparator trip |
| start_n_i | input | 1 | Low: run; high: stop |
| coast_sel_i | input | 1 | Deceleration style, high coast, low reverse torque |
| decel_i | input | 1 | Deceleration command |
| prot_off_i | input | 1 | Latched protection, forces low sides off |
| hs_en_o | output | 3 | High-side gate enables, one per phase |
| ls_en_o | output | 3 | Low-side gate enables, one per phase |

## Verification
Both enable buses are registered, so each steady-state result is due one edge after its cause, except for a pair change. A pair change shows all-off one edge after the sensor change and the new pair DEAD_CYC edges later, and the bench samples after every one of those edges to pin the exact interval. The current-limit cut is due on the BLANK_CYC-th edge of a continuous trip, so the bench samples once just before and once on that edge. The table vectors wait well past the dead interval before sampling. All sampling happens on the falling clock edge.

// File: rtl/commut_pkg.sv
package commut_pkg;

    localparam int NPH = 3;

    typedef struct packed {
        logic [NPH-1:0] hs;
        logic [NPH-1:0] ls;
    } drive_t;

    typedef enum logic [1:0] {
        MODE_STOP,
        MODE_RUN,
        MODE_COAST,
        MODE_BRAKE
    } mode_t;

    localparam drive_t DRIVE_OFF = '0;

    // Forward six-step table; bit 0 = phase A, bit 1 = B, bit 2 = C.
    function automatic drive_t step_lookup(input logic [NPH-1:0] code);
        drive_t d;
        unique case (code)
            3'b001:  d = '{hs: 3'b001, ls: 3'b010};
            3'b011:  d = '{hs: 3'b001, ls: 3'b100};
            3'b010:  d = '{hs: 3'b010, ls: 3'b100};
            3'b110:  d = '{hs: 3'b010, ls: 3'b001};
            3'b100:  d = '{hs: 3'b100, ls: 3'b001};
            3'b101:  d = '{hs: 3'b100, ls: 3'b010};
            default: d = DRIVE_OFF;
        endcase
        return d;
    endfunction

    // Advancing the table by three steps exchanges the driven sides.
    function automatic drive_t swap_sides(input drive_t d);
        drive_t r;
        r.hs = d.ls;
        r.ls = d.hs;
        return r;
    endfunction

endpackage

// File: rtl/commut_decode.sv
module commut_decode
    import commut_pkg::*;
(
    input  logic [NPH-1:0] hall_i,
    input  logic           start_n_i,
    input  logic           coast_sel_i,
    input  logic           decel_i,
    output drive_t         target_o
);

    mode_t  mode;
    drive_t fwd;

    always_comb begin
        if (start_n_i)
            mode = MODE_STOP;
        else if (!decel_i)
            mode = MODE_RUN;
        else if (coast_sel_i)
            mode = MODE_COAST;
        else
            mode = MODE_BRAKE;
    end

    always_comb begin
        fwd = step_lookup(hall_i);
        unique case (mode)
            MODE_RUN:   target_o = fwd;
            MODE_BRAKE: target_o = swap_sides(fwd);
            default:    target_o = DRIVE_OFF;
        endcase
    end

endmodule

// File: rtl/deadtime_seq.sv
module deadtime_seq
    import commut_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  drive_t target_i,
    output drive_t cur_q_o,
    output drive_t cur_d_o
);

    localparam int              DW       = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0]   DEAD_MAX = DW'(DEAD_CYC);
    localparam logic [DW-1:0]   ONE      = DW'(1);

    typedef struct packed {
        drive_t        cur;
        logic [DW-1:0] off_cnt;
    } dt_state_t;

    dt_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.cur != DRIVE_OFF) begin
            if (target_i != st_q.cur) begin
                st_d.cur     = DRIVE_OFF;
                st_d.off_cnt = ONE;
            end
        end else if (st_q.off_cnt == DEAD_MAX) begin
            st_d.cur = target_i;
        end else begin
            st_d.off_cnt = st_q.off_cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cur     <= DRIVE_OFF;
            st_q.off_cnt <= DEAD_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_q_o = st_q.cur;
    assign cur_d_o = st_d.cur;

endmodule

// File: rtl/ilim_blank.sv
module ilim_blank #(
    parameter int BLANK_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic pwm_on_i,
    output logic cut_d_o
);

    localparam int            BW   = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);
    localparam logic [BW-1:0] LAST = BW'(BLANK_CYC - 1);
    localparam logic [BW-1:0] ONE  = BW'(1);

    typedef struct packed {
        logic [BW-1:0] cnt;
        logic          cut;
    } il_state_t;

    il_state_t st_q, st_d;
    logic      fire;

    always_comb begin
        st_d = st_q;
        fire = trip_i && (st_q.cnt == LAST);
        if (!trip_i)
            st_d.cnt = '0;
        else if (st_q.cnt != LAST)
            st_d.cnt = st_q.cnt + ONE;
        // A sampled off-phase closes the period and re-arms the limiter.
        st_d.cut = pwm_on_i ? (st_q.cut | fire) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.cut <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cut_d_o = st_d.cut;

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
    import commut_pkg::*;
#(
    parameter int DEAD_CYC  = 4,
    parameter int BLANK_CYC = 100
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] hall_i,
    input  logic           pwm_on_i,
    input  logic           ilim_trip_i,
    input  logic           start_n_i,
    input  logic           coast_sel_i,
    input  logic           decel_i,
    input  logic           prot_off_i,
    output logic [NPH-1:0] hs_en_o,
    output logic [NPH-1:0] ls_en_o
);

    typedef struct packed {
        logic [NPH-1:0] ls;
    } out_state_t;

    drive_t         target;
    drive_t         cur_q;
    drive_t         cur_d;
    logic           cut_d;
    logic           ls_gate;
    logic [NPH-1:0] ls_gated;
    out_state_t     out_q, out_d;

    commut_decode u_decode (
        .hall_i      (hall_i),
        .start_n_i   (start_n_i),
        .coast_sel_i (coast_sel_i),
        .decel_i     (decel_i),
        .target_o    (target)
    );

    deadtime_seq #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk      (clk),
        .rst_n    (rst_n),
        .target_i (target),
        .cur_q_o  (cur_q),
        .cur_d_o  (cur_d)
    );

    ilim_blank #(.BLANK_CYC(BLANK_CYC)) u_ilim (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip_i   (ilim_trip_i),
        .pwm_on_i (pwm_on_i),
        .cut_d_o  (cut_d)
    );

    assign ls_gate = pwm_on_i & ~cut_d & ~prot_off_i;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        assign ls_gated[p] = cur_d.ls[p] & ls_gate;
    end

    always_comb begin
        out_d    = out_q;
        out_d.ls = ls_gated;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q.ls <= '0;
        else
            out_q <= out_d;
    end

    assign hs_en_o = cur_q.hs;
    assign ls_en_o = out_q.ls;

endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk #(
    parameter int DEAD_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hall_i,
    input logic       pwm_on_i,
    input logic       start_n_i,
    input logic       coast_sel_i,
    input logic       decel_i,
    input logic       prot_off_i,
    input logic [2:0] hs_en_o,
    input logic [2:0] ls_en_o
);

    localparam int CW = $clog2(DEAD_CYC + 2);
    localparam logic [CW-1:0] CAP = CW'(DEAD_CYC + 1);

    logic [CW-1:0] off_run_q;
    logic          seen_on_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run_q <= '0;
            seen_on_q <= 1'b0;
        end else begin
            if (hs_en_o != 3'b000) begin
                off_run_q <= '0;
                seen_on_q <= 1'b1;
            end else if (off_run_q != CAP) begin
                off_run_q <= off_run_q + CW'(1);
            end
        end
    end

    // R8
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en_o & ls_en_o) == 3'b000);

    // R8
    single_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hs_en_o) && $onehot0(ls_en_o));

    // R3
    stop_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_n_i |=> (hs_en_o == 3'b000 && ls_en_o == 3'b000));

    // R2
    bad_code_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hall_i == 3'b000 || hall_i == 3'b111) |=> (hs_en_o == 3'b000 && ls_en_o == 3'b000));

    // R5
    coast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decel_i && coast_sel_i) |=> (hs_en_o == 3'b000 && ls_en_o == 3'b000));

    // R4
    chop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_on_i |=> ls_en_o == 3'b000);

    // R10
    prot_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_off_i |=> ls_en_o == 3'b000);

    // R7
    no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en_o != 3'b000) |=> (hs_en_o == 3'b000 || $stable(hs_en_o)));

    // R7
    dead_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_on_q && hs_en_o != 3'b000 && off_run_q != '0) |-> off_run_q >= CW'(DEAD_CYC));

endmodule

bind bldc_commutator bldc_commutator_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (.*);

// File: tb/bldc_commutator_bench.sv
module bldc_commutator_bench;

    localparam int DEAD_CYC  = 4;
    localparam int BLANK_CYC = 100;
    localparam int SETTLE    = 12;
    localparam int NVEC      = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_i = 3'b001;
    logic       pwm_on_i = 1'b1;
    logic       ilim_trip_i = 1'b0;
    logic       start_n_i = 1'b1;
    logic       coast_sel_i = 1'b1;
    logic       decel_i = 1'b0;
    logic       prot_off_i = 1'b0;
    logic [2:0] hs_en_o;
    logic [2:0] ls_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bldc_commutator #(.DEAD_CYC(DEAD_CYC), .BLANK_CYC(BLANK_CYC)) u_bldc_commutator (
        .clk(clk), .rst_n(rst_n), .hall_i(hall_i), .pwm_on_i(pwm_on_i),
        .ilim_trip_i(ilim_trip_i), .start_n_i(start_n_i), .coast_sel_i(coast_sel_i),
        .decel_i(decel_i), .prot_off_i(prot_off_i), .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
    );

    // {hall, pwm, start_n, coast_sel, decel, prot, exp_hs, exp_ls, req}
    localparam logic [17:0] VEC [NVEC] = '{
        {3'b001, 5'b10100, 3'b001, 3'b010, 4'd1},   // R1
        {3'b011, 5'b10100, 3'b001, 3'b100, 4'd1},   // R1
        {3'b010, 5'b10100, 3'b010, 3'b100, 4'd1},   // R1
        {3'b110, 5'b10100, 3'b010, 3'b001, 4'd1},   // R1
        {3'b100, 5'b10100, 3'b100, 3'b001, 4'd1},   // R1
        {3'b101, 5'b10100, 3'b100, 3'b010, 4'd1},   // R1
        {3'b000, 5'b10100, 3'b000, 3'b000, 4'd2},   // R2
        {3'b111, 5'b10100, 3'b000, 3'b000, 4'd2},   // R2
        {3'b001, 5'b11100, 3'b000, 3'b000, 4'd3},   // R3
        {3'b011, 5'b10110, 3'b000, 3'b000, 4'd5},   // R5
        {3'b011, 5'b10010, 3'b100, 3'b001, 4'd6},   // R6
        {3'b110, 5'b10010, 3'b001, 3'b010, 4'd6},   // R6
        {3'b010, 5'b00100, 3'b010, 3'b000, 4'd4},   // R4
        {3'b100, 5'b10101, 3'b100, 3'b000, 4'd10},  // R10
        {3'b101, 5'b11010, 3'b000, 3'b000, 4'd3}    // R3 stop beats brake
    };

    task automatic check(input string req, input string what,
                         input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R11 reset state
        edges(3);
        check("R11", "hs in reset", hs_en_o, 3'b000);
        check("R11", "ls in reset", ls_en_o, 3'b000);
        rst_n = 1'b1;
        start_n_i = 1'b0;
        edges(SETTLE);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            {hall_i, pwm_on_i, start_n_i, coast_sel_i, decel_i, prot_off_i} = VEC[i][17:10];
            edges(SETTLE);
            tag = $sformatf("R%0d", VEC[i][3:0]);
            check(tag, $sformatf("vec %0d hs", i), hs_en_o, VEC[i][9:7]);
            check(tag, $sformatf("vec %0d ls", i), ls_en_o, VEC[i][6:4]);
        end

        // R7 exact dead interval on a pair change
        {hall_i, pwm_on_i, start_n_i, coast_sel_i, decel_i, prot_off_i} = {3'b001, 5'b10100};
        edges(SETTLE);
        check("R1", "pre dead hs", hs_en_o, 3'b001);
        hall_i = 3'b011;
        for (int k = 0; k <= DEAD_CYC; k++) begin
            edges(1);
            if (k < DEAD_CYC) begin
                check("R7", $sformatf("dead edge %0d hs", k), hs_en_o, 3'b000);
                check("R7", $sformatf("dead edge %0d ls", k), ls_en_o, 3'b000);
            end else begin
                check("R7", "new pair hs", hs_en_o, 3'b001);
                check("R7", "new pair ls", ls_en_o, 3'b100);
            end
        end

        // R4 one-edge chopping latency, high side steady
        pwm_on_i = 1'b0;
        edges(1);
        check("R4", "chop off ls", ls_en_o, 3'b000);
        check("R4", "chop off hs", hs_en_o, 3'b001);
        pwm_on_i = 1'b1;
        edges(1);
        check("R4", "chop on ls", ls_en_o, 3'b100);

        // R9 short trips ignored, counter restarts
        ilim_trip_i = 1'b1;
        edges(BLANK_CYC - 1);
        ilim_trip_i = 1'b0;
        edges(1);
        ilim_trip_i = 1'b1;
        edges(BLANK_CYC - 1);
        check("R9", "short trip ignored", ls_en_o, 3'b100);
        edges(1);
        check("R9", "trip cuts ls", ls_en_o, 3'b000);
        check("R9", "trip keeps hs", hs_en_o, 3'b001);
        ilim_trip_i = 1'b0;
        edges(3);
        check("R9", "cut held in period", ls_en_o, 3'b000);
        pwm_on_i = 1'b0;
        edges(1);
        pwm_on_i = 1'b1;
        edges(1);
        check("R9", "next period restored", ls_en_o, 3'b100);

        // R10 protection timing, then release
        prot_off_i = 1'b1;
        edges(1);
        check("R10", "prot ls", ls_en_o, 3'b000);
        check("R10", "prot hs", hs_en_o, 3'b001);
        prot_off_i = 1'b0;
        edges(1);
        check("R10", "prot release ls", ls_en_o, 3'b100);

        // R3 stop takes effect on the next edge
        start_n_i = 1'b1;
        edges(1);
        check("R3", "stop hs", hs_en_o, 3'b000);
        check("R3", "stop ls", ls_en_o, 3'b000);

        finish_run();
    end

endmodule